// File: doc/BRIEF.md
# Partitioned 8x16 Multiply Unit

This block multiplies unsigned 8-bit pixel values by signed 16-bit coefficients in four parallel lanes and rounds every lane product to 16 bits. Each lane keeps product bits [23:8] and adds one when product bit 7 is set. The increment wraps within 16 bits.

A 3-bit mode input chooses where each lane gets its pixel byte and its coefficient:
- one byte per lane from the low word of A;
- a single alpha coefficient shared by all lanes;
- the high or low byte of each 16-bit lane of A;
- a two-lane widened form that places each rounded result at a shifted position.

The result is registered with one cycle of latency and carries a valid flag. There is no state machine. The datapath is combinational and feeds a single output register that loads on valid input and holds otherwise.

Top module: `pm8_mul_unit`

## Requirements
- R1: Mode 0 (pixel-by-lane): lane i (i=0..3) multiplies byte A[8i+7:8i] by the signed coefficient B[16i+15:16i], and the rounded value goes to result bits [16i+15:16i].
- R2: Mode 1 (alpha-high): every lane i multiplies byte A[8i+7:8i] by the shared coefficient B[31:16], and the result goes to bits [16i+15:16i].
- R3: Mode 2 (alpha-low): the same as R2, with the shared coefficient taken from B[15:0].
- R4: Mode 3 (high-byte): lane i multiplies A[16i+15:16i+8] by B[16i+15:16i], and the result goes to bits [16i+15:16i].
- R5: Mode 4 (low-byte): lane i multiplies A[16i+7:16i] by B[16i+15:16i], and the result goes to bits [16i+15:16i].
- R6: Modes 5 (wide-high) and 6 (wide-low) compute only lanes 0 and 1.
  - Mode 5 takes the byte A[16i+15:16i+8]; mode 6 takes A[16i+7:16i].
  - Both multiply that byte by B[16i+15:16i].
  - Lane i's rounded result is written to bits [32i+22:32i+7], and every other result bit is 0.
- R7: The lane value is the signed 25-bit product of the zero-extended byte and the coefficient. Bits [23:8] are kept and one is added when bit 7 is set, modulo 2^16 (for example, 1 times 0xFFFF gives 0x0000).
- R8: Mode 7 is reserved and produces an all-zero result.
- R9: out_vld is high exactly one clock after a cycle with in_vld high. out_res then holds the result of that cycle's operands.
- R10: A cycle with in_vld low leaves out_res unchanged, whatever the mode and operands are.
- R11: During reset and after reset, out_vld is 0 and out_res is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_vld | input | 1 | Operands and mode are valid this cycle |
| in_mode | input | 3 | Lane sourcing mode, encoded 0..7 as in R1 to R8 |
| in_a | input | 64 | Pixel operand |
| in_b | input | 64 | Coefficient operand |
| out_vld | output | 1 | Result register holds a new result |
| out_res | output | 64 | Registered result |

## Verification
The bench builds the block with its defaults: four lanes, 8-bit pixels and 16-bit coefficients. For every mode, including the reserved one, the sweep runs every pixel value through every byte position, using rotated byte offsets. The pixels meet a set of coefficients that includes 0, 1, 0x7FFF, 0x8000, 0xFFFF and 0x0080. This reaches the rounding wrap, the sign extremes and the placement of the widened modes. Directed steps then cover reset, the hold on idle cycles and the valid timing.

// File: rtl/pm8_pkg.sv
package pm8_pkg;
    typedef enum logic [2:0] {
        MD_PIX      = 3'd0,
        MD_ALPHA_HI = 3'd1,
        MD_ALPHA_LO = 3'd2,
        MD_HIBYTE   = 3'd3,
        MD_LOBYTE   = 3'd4,
        MD_WIDE_HI  = 3'd5,
        MD_WIDE_LO  = 3'd6,
        MD_NONE     = 3'd7
    } pm_mode_e;
endpackage

// File: rtl/pm8_operand_sel.sv
module pm8_operand_sel
    import pm8_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int PIX_W  = 8,
    parameter int COEF_W = 16
) (
    input  pm_mode_e                    mode,
    input  logic [LANES*COEF_W-1:0]     a,
    input  logic [LANES*COEF_W-1:0]     b,
    output logic [LANES*PIX_W-1:0]      pix,
    output logic [LANES*COEF_W-1:0]     coef,
    output logic [LANES-1:0]            lane_en
);
    localparam int HALF = LANES / 2;

    always_comb begin
        pix     = '0;
        coef    = '0;
        lane_en = '0;
        for (int i = 0; i < LANES; i++) begin
            unique case (mode)
                MD_PIX: begin
                    pix[i*PIX_W +: PIX_W]    = a[i*PIX_W +: PIX_W];
                    coef[i*COEF_W +: COEF_W] = b[i*COEF_W +: COEF_W];
                    lane_en[i]               = 1'b1;
                end
                MD_ALPHA_HI: begin
                    pix[i*PIX_W +: PIX_W]    = a[i*PIX_W +: PIX_W];
                    coef[i*COEF_W +: COEF_W] = b[COEF_W +: COEF_W];
                    lane_en[i]               = 1'b1;
                end
                MD_ALPHA_LO: begin
                    pix[i*PIX_W +: PIX_W]    = a[i*PIX_W +: PIX_W];
                    coef[i*COEF_W +: COEF_W] = b[0 +: COEF_W];
                    lane_en[i]               = 1'b1;
                end
                MD_HIBYTE: begin
                    pix[i*PIX_W +: PIX_W]    = a[i*COEF_W + PIX_W +: PIX_W];
                    coef[i*COEF_W +: COEF_W] = b[i*COEF_W +: COEF_W];
                    lane_en[i]               = 1'b1;
                end
                MD_LOBYTE: begin
                    pix[i*PIX_W +: PIX_W]    = a[i*COEF_W +: PIX_W];
                    coef[i*COEF_W +: COEF_W] = b[i*COEF_W +: COEF_W];
                    lane_en[i]               = 1'b1;
                end
                MD_WIDE_HI: begin
                    if (i < HALF) begin
                        pix[i*PIX_W +: PIX_W]    = a[i*COEF_W + PIX_W +: PIX_W];
                        coef[i*COEF_W +: COEF_W] = b[i*COEF_W +: COEF_W];
                        lane_en[i]               = 1'b1;
                    end
                end
                MD_WIDE_LO: begin
                    if (i < HALF) begin
                        pix[i*PIX_W +: PIX_W]    = a[i*COEF_W +: PIX_W];
                        coef[i*COEF_W +: COEF_W] = b[i*COEF_W +: COEF_W];
                        lane_en[i]               = 1'b1;
                    end
                end
                MD_NONE: begin
                    lane_en[i] = 1'b0;
                end
                default: begin
                    lane_en[i] = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/pm8_lane_mul.sv
module pm8_lane_mul #(
    parameter int PIX_W  = 8,
    parameter int COEF_W = 16
) (
    input  logic [PIX_W-1:0]  pix,
    input  logic [COEF_W-1:0] coef,
    output logic [COEF_W-1:0] res
);
    localparam int PW = PIX_W + COEF_W + 1;

    logic signed [PW-1:0] pix_ext;
    logic signed [PW-1:0] coef_ext;
    logic signed [PW-1:0] prod;

    always_comb begin
        pix_ext  = signed'({{(COEF_W+1){1'b0}}, pix});
        coef_ext = signed'({{(PIX_W+1){coef[COEF_W-1]}}, coef});
        prod     = pix_ext * coef_ext;
        res      = prod[PIX_W+COEF_W-1:PIX_W]
                 + {{(COEF_W-1){1'b0}}, prod[PIX_W-1]};
    end
endmodule

// File: rtl/pm8_packer.sv
module pm8_packer
    import pm8_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int PIX_W  = 8,
    parameter int COEF_W = 16
) (
    input  pm_mode_e                mode,
    input  logic [LANES*COEF_W-1:0] lane_res,
    input  logic [LANES-1:0]        lane_en,
    output logic [LANES*COEF_W-1:0] packed_res
);
    localparam int HALF   = LANES / 2;
    localparam int WOFF   = PIX_W - 1;
    localparam int WSTEP  = 2 * COEF_W;

    logic wide;

    always_comb begin
        wide       = (mode == MD_WIDE_HI) || (mode == MD_WIDE_LO);
        packed_res = '0;
        for (int i = 0; i < LANES; i++) begin
            if (wide) begin
                if (i < HALF && lane_en[i])
                    packed_res[i*WSTEP + WOFF +: COEF_W] = lane_res[i*COEF_W +: COEF_W];
            end else if (lane_en[i]) begin
                packed_res[i*COEF_W +: COEF_W] = lane_res[i*COEF_W +: COEF_W];
            end
        end
    end
endmodule

// File: rtl/pm8_mul_unit.sv
module pm8_mul_unit
    import pm8_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int PIX_W  = 8,
    parameter int COEF_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_vld,
    input  logic [2:0]              in_mode,
    input  logic [LANES*COEF_W-1:0] in_a,
    input  logic [LANES*COEF_W-1:0] in_b,
    output logic                    out_vld,
    output logic [LANES*COEF_W-1:0] out_res
);
    localparam int DW = LANES * COEF_W;

    pm_mode_e                mode;
    logic [LANES*PIX_W-1:0]  sel_pix;
    logic [DW-1:0]           sel_coef;
    logic [LANES-1:0]        lane_en;
    logic [DW-1:0]           lane_res;
    logic [DW-1:0]           packed_res;

    assign mode = pm_mode_e'(in_mode);

    pm8_operand_sel #(.LANES(LANES), .PIX_W(PIX_W), .COEF_W(COEF_W)) u_sel (
        .mode    (mode),
        .a       (in_a),
        .b       (in_b),
        .pix     (sel_pix),
        .coef    (sel_coef),
        .lane_en (lane_en)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pm8_lane_mul #(.PIX_W(PIX_W), .COEF_W(COEF_W)) u_mul (
            .pix  (sel_pix[g*PIX_W +: PIX_W]),
            .coef (sel_coef[g*COEF_W +: COEF_W]),
            .res  (lane_res[g*COEF_W +: COEF_W])
        );
    end

    pm8_packer #(.LANES(LANES), .PIX_W(PIX_W), .COEF_W(COEF_W)) u_pack (
        .mode       (mode),
        .lane_res   (lane_res),
        .lane_en    (lane_en),
        .packed_res (packed_res)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_res <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld)
                out_res <= packed_res;
        end
    end
endmodule

// File: rtl/pm8_mul_unit_chk.sv
module pm8_mul_unit_chk #(
    parameter int LANES  = 4,
    parameter int PIX_W  = 8,
    parameter int COEF_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_vld,
    input logic [2:0]              in_mode,
    input logic [LANES*COEF_W-1:0] in_a,
    input logic [LANES*COEF_W-1:0] in_b,
    input logic                    out_vld,
    input logic [LANES*COEF_W-1:0] out_res
);
    localparam int DW = LANES * COEF_W;

    function automatic logic [DW-1:0] wide_mask();
        logic [DW-1:0] m;
        m = '0;
        for (int i = 0; i < LANES / 2; i++)
            m[i*2*COEF_W + PIX_W - 1 +: COEF_W] = '1;
        return m;
    endfunction

    localparam logic [DW-1:0] WMASK = wide_mask();

    assert_vld_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);

    assert_vld_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);

    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable(out_res));

    assert_wide_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && (in_mode == 3'd5 || in_mode == 3'd6)) |=> ((out_res & ~WMASK) == '0));

    assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_mode == 3'd7) |=> (out_res == '0));

    assert_zero_pixels_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_a == '0) |=> (out_res == '0));

    always_comb begin
        if (!rst_n) begin
            assert_reset_R11: assert (out_vld == 1'b0);
        end
    end
endmodule

bind pm8_mul_unit pm8_mul_unit_chk #(.LANES(LANES), .PIX_W(PIX_W), .COEF_W(COEF_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .in_mode (in_mode),
    .in_a    (in_a),
    .in_b    (in_b),
    .out_vld (out_vld),
    .out_res (out_res)
);

// File: tb/tb_pm8_mul_unit.sv
module tb_pm8_mul_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [2:0]  in_mode = 3'd0;
    logic [63:0] in_a = '0;
    logic [63:0] in_b = '0;
    logic        out_vld;
    logic [63:0] out_res;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pm8_mul_unit dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_mode(in_mode),
        .in_a(in_a), .in_b(in_b), .out_vld(out_vld), .out_res(out_res)
    );

    function automatic logic [15:0] ref_lane(input logic [7:0] p, input logic [15:0] c);
        int prod;
        logic [31:0] u;
        prod = int'(p) * int'($signed(c));
        u = prod;
        return u[23:8] + {15'b0, u[7]};
    endfunction

    function automatic logic [63:0] ref_res(input logic [2:0] m, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] r;
        r = '0;
        for (int i = 0; i < 4; i++) begin
            case (m)
                3'd0: r[16*i +: 16] = ref_lane(a[8*i +: 8], b[16*i +: 16]);
                3'd1: r[16*i +: 16] = ref_lane(a[8*i +: 8], b[31:16]);
                3'd2: r[16*i +: 16] = ref_lane(a[8*i +: 8], b[15:0]);
                3'd3: r[16*i +: 16] = ref_lane(a[16*i+8 +: 8], b[16*i +: 16]);
                3'd4: r[16*i +: 16] = ref_lane(a[16*i +: 8], b[16*i +: 16]);
                3'd5: if (i < 2) r[32*i+7 +: 16] = ref_lane(a[16*i+8 +: 8], b[16*i +: 16]);
                3'd6: if (i < 2) r[32*i+7 +: 16] = ref_lane(a[16*i +: 8], b[16*i +: 16]);
                default: r = '0;
            endcase
        end
        return r;
    endfunction

    function automatic string tag_of(input logic [2:0] m);
        case (m)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5, 3'd6: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    logic [15:0] coefs [8];

    initial begin
        coefs[0] = 16'h0000; coefs[1] = 16'h0001; coefs[2] = 16'h7FFF; coefs[3] = 16'h8000;
        coefs[4] = 16'hFFFF; coefs[5] = 16'h0080; coefs[6] = 16'h1234; coefs[7] = 16'hC3A5;

        // R11: reset state
        repeat (3) @(negedge clk);
        check64("R11", {63'b0, out_vld}, 64'd0);
        check64("R11", out_res, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check64("R11", {63'b0, out_vld}, 64'd0);
        check64("R11", out_res, 64'd0);

        // R7: wrap of the rounding increment (1 * 0xFFFF -> 0x0000)
        in_vld = 1'b1; in_mode = 3'd0;
        in_a = 64'h0000_0000_0101_0101; in_b = 64'hFFFF_FFFF_FFFF_FFFF;
        @(negedge clk);
        check64("R7", out_res, 64'h0);
        // R7: 255 * 0x7FFF -> 0x7F7F, 0x80 * 0x0001 -> round up to 1
        in_a = 64'h0000_0000_FF80_FF80; in_b = 64'h7FFF_0001_7FFF_0001;
        @(negedge clk);
        check64("R7", out_res, 64'h7F7F_0001_7F7F_0001);
        // R9: valid one cycle later
        check64("R9", {63'b0, out_vld}, 64'd1);

        // R10: idle cycles leave the result unchanged
        in_vld = 1'b0; in_mode = 3'd3;
        in_a = 64'hFFFF_FFFF_FFFF_FFFF; in_b = 64'h7FFF_7FFF_7FFF_7FFF;
        @(negedge clk);
        check64("R9", {63'b0, out_vld}, 64'd0);
        check64("R10", out_res, 64'h7F7F_0001_7F7F_0001);
        @(negedge clk);
        check64("R10", out_res, 64'h7F7F_0001_7F7F_0001);

        // Sweep: every mode, every pixel value, rotated coefficients
        for (int m = 0; m < 8; m++) begin
            for (int c = 0; c < 8; c++) begin
                for (int p = 0; p < 256; p++) begin
                    logic [63:0] a, b;
                    for (int k = 0; k < 8; k++) a[8*k +: 8] = 8'((p + 29 * k) & 255);
                    for (int k = 0; k < 4; k++) b[16*k +: 16] = coefs[(c + k) % 8];
                    in_vld = 1'b1; in_mode = 3'(m); in_a = a; in_b = b;
                    @(negedge clk);
                    check64(tag_of(3'(m)), out_res, ref_res(3'(m), a, b));
                end
            end
        end

        // R8: reserved mode after a nonzero result
        in_mode = 3'd0; in_a = 64'h0000_0000_1111_1111; in_b = 64'h0100_0100_0100_0100;
        @(negedge clk);
        check64("R1", out_res, 64'h0011_0011_0011_0011);
        in_mode = 3'd7;
        @(negedge clk);
        check64("R8", out_res, 64'h0);
        in_vld = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule